// File: doc/BRIEF.md
# Retention-Binned Multi-Rate DRAM Refresh Controller

This block issues per-row refresh commands to a DRAM bank and refreshes rows at different rates depending on how well they hold their charge. A retention profiling step, performed outside the block, sorts rows into a fast bin (weak rows), a middle bin, and an implicit default bin that holds every other row. The fast and middle bins are stored as two compact Bloom filters rather than as a per-row table. Software loads them through a small programming port: each row insert sets two filter bits, and a wipe strobe empties a whole filter.

An epoch timer divides time into base periods of `EPOCH_CYCLES` clocks (nominally 64 ms) and keeps an epoch count modulo 4. At the start of each epoch the block walks every row address in ascending order and queries both filters. Rows in the fast bin are refreshed every epoch. Middle-bin rows are refreshed every second epoch. All remaining rows are refreshed once every fourth epoch. A Bloom filter false positive can only add refreshes and never removes one. Each refresh is a one-cycle request that carries the row address. A busy flag covers the whole refresh window, during which the bank cannot serve traffic.

Top module: `rfsh_binned_ctrl`

## Requirements
- R1: During reset and afterwards until the first epoch boundary, `ref_req` and `busy` are 0. The first epoch boundary comes `EPOCH_CYCLES` clocks after reset is released, so no request can appear before that clock.
- R2: At each epoch boundary the block starts one scan. The scan visits rows 0 to 2^ROW_W-1 in ascending order and issues at most one request per row, so the request addresses within a scan strictly increase.
- R3: A row that is a member of the fast filter is refreshed in every epoch.
- R4: A row that is a member of the middle filter but not of the fast filter is refreshed only in epochs whose count is even (0 or 2).
- R5: A row that is in neither filter is refreshed only in epochs whose count is 0.
- R6: A row that is in both filters is refreshed exactly once per epoch. The fast filter is consulted first and takes precedence.
- R7: Each filter holds 256 bits. Take the row zero-extended to 32 bits as r, and let fold(x) be the XOR of the four bytes of x. The two bit indices are then h0 = fold(r) and h1 = fold(r ^ (r << 3)), with the shift done in 32 bits. A row is a member only when both of its bits are set. An insert sets both bits, so a row that was never inserted becomes a member whenever other inserts happened to set both of its bits.
- R8: A wipe strobe zeroes the whole selected filter on the next clock edge. An insert into the same filter in that same cycle is discarded. `load_bin` = 0 selects the fast filter and 1 selects the middle filter.
- R9: `ref_req` is high for exactly one cycle per refresh, and `busy` rises in that same cycle. `busy` then stays high for exactly `REF_HOLD` consecutive cycles.
- R10: The epoch count advances by one, modulo 4, at every epoch boundary. The first scan after reset uses count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Insert `load_row` into the filter chosen by `load_bin` |
| load_bin | input | 1 | 0 = fast filter, 1 = middle filter |
| load_row | input | ROW_W | Row address to insert |
| wipe_fast | input | 1 | Zero the fast filter |
| wipe_mid | input | 1 | Zero the middle filter |
| ref_req | output | 1 | One-cycle refresh request |
| ref_row | output | ROW_W | Row address of the request |
| busy | output | 1 | Bank is held for a refresh |

## Verification
The assertions assume that a scan always finishes before the next epoch boundary. This holds when 2^ROW_W·(1+REF_HOLD)+1 is below `EPOCH_CYCLES`, and the bench sizes its parameters (64 rows, hold 3, epoch 600) to meet it. The rate assertions also assume that filter contents do not change while a scan is running. The bench therefore programs or wipes filters only in idle time: it keeps the last row permanently in the fast filter, so the request for that row marks the end of every scan. The expected request stream comes from a model of the filter bits, which includes any false positives.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int IDX_W     = 8;
    localparam int FILT_BITS = 1 << IDX_W;
    localparam int NUM_BINS  = 2;
    localparam int EPOCH_W   = 2;

    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [EPOCH_W-1:0] epoch_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } scan_state_t;

    typedef enum logic {
        BIN_FAST = 1'b0,
        BIN_MID  = 1'b1
    } bin_t;

    typedef struct packed {
        idx_t h0;
        idx_t h1;
    } hash_pair_t;

    function automatic idx_t byte_fold(input logic [31:0] v);
        return v[7:0] ^ v[15:8] ^ v[23:16] ^ v[31:24];
    endfunction

    function automatic hash_pair_t row_hash(input logic [31:0] r);
        hash_pair_t hp;
        hp.h0 = byte_fold(r);
        hp.h1 = byte_fold(r ^ (r << 3));
        return hp;
    endfunction

    // Fast bin has priority; middle bin on even epochs; default on epoch 0.
    function automatic logic row_due(input logic in_fast, input logic in_mid,
                                     input epoch_t ep);
        return in_fast | (in_mid & ~ep[0]) | (ep == '0);
    endfunction

endpackage

// File: rtl/rfsh_epoch_timer.sv
module rfsh_epoch_timer
    import rfsh_pkg::*;
#(
    parameter int EPOCH_CYCLES = 3_200_000
) (
    input  logic   clk,
    input  logic   rst,
    output logic   tick,
    output epoch_t epoch
);
    localparam int CNT_W = (EPOCH_CYCLES > 2) ? $clog2(EPOCH_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EPOCH_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            epoch <= '0;
        end else if (tick) begin
            cnt   <= '0;
            epoch <= epoch + 1'b1;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rfsh_bloom.sv
module rfsh_bloom
    import rfsh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wipe,
    input  logic                 set_en,
    input  hash_pair_t           set_key,
    input  hash_pair_t           q_key,
    output logic                 hit,
    output logic [FILT_BITS-1:0] bits
);
    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            bits <= '0;
        end else if (set_en) begin
            bits[set_key.h0] <= 1'b1;
            bits[set_key.h1] <= 1'b1;
        end
    end

    assign hit = bits[q_key.h0] & bits[q_key.h1];

endmodule

// File: rtl/rfsh_scan_ctrl.sv
module rfsh_scan_ctrl
    import rfsh_pkg::*;
#(
    parameter int ROW_W    = 12,
    parameter int REF_HOLD = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  epoch_t           epoch,
    input  logic             hit_fast,
    input  logic             hit_mid,
    output logic [ROW_W-1:0] cur_row,
    output epoch_t           scan_epoch,
    output logic             ref_req,
    output logic [ROW_W-1:0] ref_row,
    output logic             busy,
    output logic             idle
);
    localparam int HOLD_W = (REF_HOLD > 1) ? $clog2(REF_HOLD) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(REF_HOLD - 1);
    localparam logic [ROW_W-1:0]  ROW_LAST  = '1;

    scan_state_t       st;
    logic [HOLD_W-1:0] hold_cnt;
    logic              due_now;

    assign due_now = row_due(hit_fast, hit_mid, scan_epoch);
    assign busy    = (st == ST_HOLD);
    assign idle    = (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cur_row    <= '0;
            scan_epoch <= '0;
            ref_req    <= 1'b0;
            ref_row    <= '0;
            hold_cnt   <= '0;
        end else begin
            ref_req <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (tick) begin
                        cur_row    <= '0;
                        scan_epoch <= epoch;
                        st         <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (due_now) begin
                        ref_req  <= 1'b1;
                        ref_row  <= cur_row;
                        hold_cnt <= HOLD_LAST;
                        st       <= ST_HOLD;
                    end else if (cur_row == ROW_LAST) begin
                        st <= ST_IDLE;
                    end else begin
                        cur_row <= cur_row + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (hold_cnt == '0) begin
                        if (cur_row == ROW_LAST) begin
                            st <= ST_IDLE;
                        end else begin
                            cur_row <= cur_row + 1'b1;
                            st      <= ST_SCAN;
                        end
                    end else begin
                        hold_cnt <= hold_cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rfsh_binned_ctrl.sv
module rfsh_binned_ctrl
    import rfsh_pkg::*;
#(
    parameter int ROW_W        = 12,
    parameter int EPOCH_CYCLES = 3_200_000,
    parameter int REF_HOLD     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic             load_bin,
    input  logic [ROW_W-1:0] load_row,
    input  logic             wipe_fast,
    input  logic             wipe_mid,
    output logic             ref_req,
    output logic [ROW_W-1:0] ref_row,
    output logic             busy
);
    logic                 tick;
    epoch_t               epoch;
    epoch_t               scan_epoch;
    logic [ROW_W-1:0]     cur_row;
    logic                 idle;
    hash_pair_t           q_key;
    hash_pair_t           set_key;
    logic [NUM_BINS-1:0]  hit;
    logic [NUM_BINS-1:0]  wipe_vec;
    logic [FILT_BITS-1:0] fbits [NUM_BINS];

    assign q_key    = row_hash(32'(cur_row));
    assign set_key  = row_hash(32'(load_row));
    assign wipe_vec = {wipe_mid, wipe_fast};

    rfsh_epoch_timer #(.EPOCH_CYCLES(EPOCH_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .epoch (epoch)
    );

    for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
        rfsh_bloom u_filt (
            .clk     (clk),
            .rst     (rst),
            .wipe    (wipe_vec[g]),
            .set_en  (load_en && (load_bin == g[0])),
            .set_key (set_key),
            .q_key   (q_key),
            .hit     (hit[g]),
            .bits    (fbits[g])
        );
    end

    rfsh_scan_ctrl #(.ROW_W(ROW_W), .REF_HOLD(REF_HOLD)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .epoch      (epoch),
        .hit_fast   (hit[BIN_FAST]),
        .hit_mid    (hit[BIN_MID]),
        .cur_row    (cur_row),
        .scan_epoch (scan_epoch),
        .ref_req    (ref_req),
        .ref_row    (ref_row),
        .busy       (busy),
        .idle       (idle)
    );

endmodule

// File: rtl/rfsh_binned_ctrl_chk.sv
module rfsh_binned_ctrl_chk
    import rfsh_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ref_req,
    input logic [ROW_W-1:0]     ref_row,
    input logic                 busy,
    input logic                 tick,
    input logic                 idle,
    input epoch_t               epoch,
    input epoch_t               scan_epoch,
    input logic [NUM_BINS-1:0]  hit,
    input logic                 wipe_fast,
    input logic                 wipe_mid,
    input logic [FILT_BITS-1:0] bits_fast,
    input logic [FILT_BITS-1:0] bits_mid
);
    logic             seen;
    logic [ROW_W-1:0] last_row;
    logic             scanning;

    assign scanning = !idle && !busy;

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            seen     <= 1'b0;
            last_row <= '0;
        end else if (ref_req) begin
            seen     <= 1'b1;
            last_row <= ref_row;
        end
    end

    assert_req_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> busy);
    assert_req_single_R9: assert property (@(posedge clk) disable iff (rst)
        ref_req |=> !ref_req);
    assert_row_order_R2: assert property (@(posedge clk) disable iff (rst)
        (ref_req && seen) |-> (ref_row > last_row));
    assert_tick_idle_R2: assert property (@(posedge clk) disable iff (rst)
        tick |-> idle);
    assert_epoch_step_R10: assert property (@(posedge clk) disable iff (rst)
        tick |=> (epoch == $past(epoch) + 2'd1));
    assert_fast_served_R3: assert property (@(posedge clk) disable iff (rst)
        (scanning && hit[BIN_FAST]) |=> ref_req);
    assert_mid_even_R4: assert property (@(posedge clk) disable iff (rst)
        (ref_req && scan_epoch[0]) |-> $past(hit[BIN_FAST]));
    assert_default_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (ref_req && scan_epoch != 2'd0) |-> $past(hit[BIN_FAST] || hit[BIN_MID]));
    assert_wipe_fast_R8: assert property (@(posedge clk) disable iff (rst)
        wipe_fast |=> (bits_fast == '0));
    assert_wipe_mid_R8: assert property (@(posedge clk) disable iff (rst)
        wipe_mid |=> (bits_mid == '0));

endmodule

bind rfsh_binned_ctrl rfsh_binned_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_req    (ref_req),
    .ref_row    (ref_row),
    .busy       (busy),
    .tick       (tick),
    .idle       (idle),
    .epoch      (epoch),
    .scan_epoch (scan_epoch),
    .hit        (hit),
    .wipe_fast  (wipe_fast),
    .wipe_mid   (wipe_mid),
    .bits_fast  (fbits[0]),
    .bits_mid   (fbits[1])
);

// File: tb/test_rfsh_binned_ctrl.sv
`timescale 1ns/1ps
module test_rfsh_binned_ctrl;

    localparam int ROW_W    = 6;
    localparam int NROWS    = 1 << ROW_W;
    localparam int EPOCH    = 600;
    localparam int HOLD     = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             load_en = 1'b0;
    logic             load_bin = 1'b0;
    logic [ROW_W-1:0] load_row = '0;
    logic             wipe_fast = 1'b0;
    logic             wipe_mid = 1'b0;
    logic             ref_req;
    logic [ROW_W-1:0] ref_row;
    logic             busy;

    always #10 clk = ~clk;

    rfsh_binned_ctrl #(.ROW_W(ROW_W), .EPOCH_CYCLES(EPOCH), .REF_HOLD(HOLD)) i_rfsh_binned_ctrl (
        .clk(clk), .rst(rst), .load_en(load_en), .load_bin(load_bin), .load_row(load_row),
        .wipe_fast(wipe_fast), .wipe_mid(wipe_mid),
        .ref_req(ref_req), .ref_row(ref_row), .busy(busy)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    int    cyc      = 0;
    int    first_req_cyc = -1;
    int    bench_ep = 0;
    int    exp_row[$];
    string exp_tag[$];
    bit    mfast[256];
    bit    mmid[256];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R7 hash, computed from the requirement text
    function automatic int fold8(input int unsigned v);
        return int'((v ^ (v >> 8) ^ (v >> 16) ^ (v >> 24)) & 32'hFF);
    endfunction
    function automatic int hx0(input int r); return fold8(r); endfunction
    function automatic int hx1(input int r); return fold8(r ^ (r << 3)); endfunction
    function automatic bit in_fast(input int r); return mfast[hx0(r)] && mfast[hx1(r)]; endfunction
    function automatic bit in_mid(input int r);  return mmid[hx0(r)] && mmid[hx1(r)];   endfunction

    task automatic load(input bit bin, input int r);
        @(negedge clk);
        load_en = 1'b1; load_bin = bin; load_row = ROW_W'(r);
        if (!wipe_fast && !bin) begin mfast[hx0(r)] = 1; mfast[hx1(r)] = 1; end
        if (!wipe_mid && bin)   begin mmid[hx0(r)] = 1;  mmid[hx1(r)] = 1;  end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic wipe(input bit bin);
        @(negedge clk);
        if (bin) begin wipe_mid = 1'b1; foreach (mmid[i]) mmid[i] = 0; end
        else     begin wipe_fast = 1'b1; foreach (mfast[i]) mfast[i] = 0; end
        @(negedge clk);
        wipe_fast = 1'b0; wipe_mid = 1'b0;
    endtask

    // R8: wipe and insert in the same cycle; insert must be dropped
    task automatic wipe_mid_with_load(input int r);
        @(negedge clk);
        wipe_mid = 1'b1; load_en = 1'b1; load_bin = 1'b1; load_row = ROW_W'(r);
        foreach (mmid[i]) mmid[i] = 0;
        @(negedge clk);
        wipe_mid = 1'b0; load_en = 1'b0;
    endtask

    // Driver: push the expected refresh stream for n epochs
    task automatic push_epochs(input int n);
        for (int e = 0; e < n; e++) begin
            for (int r = 0; r < NROWS; r++) begin
                bit f = in_fast(r);
                bit m = in_mid(r);
                if (f || (m && (bench_ep % 2 == 0)) || bench_ep == 0) begin
                    exp_row.push_back(r);
                    if (f && m)      exp_tag.push_back("R6 both-bins row");
                    else if (f)      exp_tag.push_back("R3 fast row");
                    else if (m)      exp_tag.push_back("R4 mid row");
                    else             exp_tag.push_back("R5 default row");
                end
            end
            bench_ep = (bench_ep + 1) % 4;
        end
    endtask

    task automatic drain(input string what);
        int waited = 0;
        while (exp_row.size() != 0 && waited < 6 * EPOCH) begin
            @(negedge clk);
            waited++;
        end
        check(exp_row.size() == 0, {"R2 all refreshes of ", what, " issued; remaining"},
              exp_row.size(), 0);
        repeat (HOLD + 2) @(negedge clk);
    endtask

    // Monitor: compare requests and busy windows
    int busy_run = 0;
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (ref_req) begin
                if (first_req_cyc < 0) first_req_cyc = cyc;
                check(busy === 1'b1, "R9 busy with ref_req", int'(busy), 1);
                if (exp_row.size() == 0) begin
                    check(1'b0, "R2 unexpected refresh row", int'(ref_row), -1);
                end else begin
                    automatic int    er = exp_row.pop_front();
                    automatic string et = exp_tag.pop_front();
                    check(int'(ref_row) == er, et, int'(ref_row), er);
                end
            end
            if (busy) busy_run++;
            else if (busy_run != 0) begin
                check(busy_run == HOLD, "R9 busy window length", busy_run, HOLD);
                busy_run = 0;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(ref_req === 1'b0, "R1 ref_req in reset", int'(ref_req), 0);
        check(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        check(ref_req === 1'b0 && busy === 1'b0, "R1 idle after reset", int'(busy), 0);

        // Phase 1: row 63 keeps marking scan end; row 30 sits in both bins
        load(1'b0, NROWS - 1);
        load(1'b0, 5);
        load(1'b0, 30);
        load(1'b1, 10);
        load(1'b1, 20);
        load(1'b1, 30);
        push_epochs(4);
        drain("phase1 epochs 0..3 (R10)");
        check(first_req_cyc >= EPOCH, "R1 first request not before epoch boundary",
              first_req_cyc, EPOCH);

        // Phase 2: wipe fast filter (R8), row 5 falls back to default
        wipe(1'b0);
        load(1'b0, NROWS - 1);
        load(1'b1, 7);
        push_epochs(4);
        drain("phase2 after fast wipe (R8)");

        // Phase 3: wipe mid with simultaneous insert dropped (R8), rows 10/20/30/7 default
        wipe_mid_with_load(40);
        push_epochs(3);
        drain("phase3 after mid wipe (R8)");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired, pending refreshes=%0d expected=0", exp_row.size());
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule